// File: doc/BRIEF.md
# Dual-Lane Serial Converter Result Shifter

This block is the device side of a two-channel serial converter port. A host pulls chip select low and then toggles a serial clock. On the chip-select falling edge the block captures two 12-bit results, A and B, and enters hold. From that point it shifts both results out on two data lanes, most significant bit first. Each lane is a data bit plus an output-enable, which models a three-state pin.

Each 16-clock slot carries two zero bits, then twelve result bits, then two zero bits. The first zero is on the lane before any clock edge. If the host keeps chip select low for a second slot, lane A sends channel B's result and lane B sends channel A's result, using the same framing. Both lanes go back to three-state when chip select rises or after the 32nd counted falling clock edge, whichever comes first. The hold indicator drops back to track on the first rising clock edge after the 13th counted falling edge.

Chip select and serial clock are plain inputs sampled on the system clock `clk`. An edge on them is acted on at the first `clk` edge that sees it, so every output changes one `clk` cycle after the sample that shows the edge. The result inputs carry no valid/ready pair. They are sampled only at the chip-select falling edge, so no back-pressure exists and the producer may change them at any other time.

Top module: `serial_adc_shifter`

## Requirements
- R1: In the `clk` cycle after a chip-select falling edge is sampled, `oe_a`, `oe_b` and `track_hold` are 1 and both data bits are 0. This is the first leading zero.
- R2: The first counted falling edge of `sclk` drives 0 on both lanes. This is the second leading zero.
- R3: Counted falling edges 2 to 13 drive bits 11 down to 0 of the lane's own result (A on `dout_a`, B on `dout_b`). Each bit stays until the next counted falling edge.
- R4: `track_hold` stays 1 through the 13th counted falling edge. It goes to 0 on the first rising `sclk` edge after that falling edge, and not on any earlier rising edge.
- R5: Counted falling edges 14 and 15 drive 0 on both lanes.
- R6: Counted falling edges 16 and 17 drive 0. Edges 18 to 29 drive bits 11 down to 0 of the other channel's result (B on `dout_a`, A on `dout_b`). Edges 30 and 31 drive 0.
- R7: A chip-select rising edge sets `oe_a`, `oe_b`, `track_hold` and both data bits to 0 in the next cycle.
- R8: At the 32nd counted falling edge both enables go to 0. While an enable is 0, its data bit is 0. Further `sclk` edges have no effect until the next chip-select falling edge.
- R9: An `sclk` falling edge sampled in the same `clk` cycle as the chip-select falling edge is not counted. The next falling edge counts as the first.
- R10: A rising `sclk` edge before the first counted falling edge changes neither the lanes nor the counting.
- R11: Changes on `res_a` and `res_b` after the chip-select falling edge have no effect on the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| res_a | input | 12 | Channel A result, captured at chip-select fall |
| res_b | input | 12 | Channel B result, captured at chip-select fall |
| dout_a | output | 1 | Lane A data bit |
| oe_a | output | 1 | Lane A drive enable (0 = three-state) |
| dout_b | output | 1 | Lane B data bit |
| oe_b | output | 1 | Lane B drive enable (0 = three-state) |
| track_hold | output | 1 | 1 while the sample is held, 0 while tracking |

## Verification
The assertions assume that `cs_n` and `sclk` are already synchronous to `clk` and that each level lasts at least one `clk` sample. Under that assumption, every edge the checker sees is also an edge the block sees. They also assume that the data lanes only move on a counted falling edge or a chip-select change. The bench keeps within these limits by changing `cs_n`, `sclk` and the results only on the falling edge of `clk`, and by holding each level for one full `clk` period. It checks the lanes at the next falling edge of `clk`, exactly one register stage after the change.

// File: rtl/sdx_pkg.sv
`timescale 1ns/1ps
package sdx_pkg;
  // Defaults for the result width and the zero padding around each slot
  localparam int unsigned DEF_DATA_W  = 12;
  localparam int unsigned DEF_LEAD_Z  = 2;
  localparam int unsigned DEF_TRAIL_Z = 2;
  localparam int unsigned N_CHAN      = 2;

  // One-cycle event pulses seen on a sampled control line
  typedef struct packed {
    logic fall;
    logic rise;
  } edge_t;
endpackage

// File: rtl/sdx_edge_detect.sv
`timescale 1ns/1ps
module sdx_edge_detect
  import sdx_pkg::*;
#(
  parameter logic IDLE = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  din,
  output edge_t ev
);
  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IDLE;
    else        last_q <= din;
  end

  assign ev.fall = last_q & ~din;
  assign ev.rise = ~last_q & din;
endmodule

// File: rtl/sdx_frame_ctrl.sv
`timescale 1ns/1ps
module sdx_frame_ctrl
  import sdx_pkg::*;
#(
  parameter int unsigned TOTAL   = 32,
  parameter int unsigned HOLD_AT = 13,
  localparam int unsigned CW     = $clog2(TOTAL + 1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  edge_t cs_ev,
  input  edge_t sk_ev,
  output logic  load,
  output logic  clear,
  output logic  shift,
  output logic  active,
  output logic  hold
);
  logic [CW-1:0] cnt_q;

  // cs_n falls low as active-low select, so cs fall starts a transfer
  assign load  = cs_ev.fall;
  assign clear = cs_ev.rise;
  // a clock fall that coincides with select fall is dropped here
  assign shift = active & sk_ev.fall & ~cs_ev.fall & ~cs_ev.rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      active <= 1'b0;
      hold   <= 1'b0;
    end else if (cs_ev.fall) begin
      cnt_q  <= '0;
      active <= 1'b1;
      hold   <= 1'b1;
    end else if (cs_ev.rise) begin
      cnt_q  <= '0;
      active <= 1'b0;
      hold   <= 1'b0;
    end else if (active) begin
      if (shift) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(TOTAL - 1)) active <= 1'b0;
      end
      if (sk_ev.rise && hold && (cnt_q >= CW'(HOLD_AT))) hold <= 1'b0;
    end
  end
endmodule

// File: rtl/sdx_lane_shifter.sv
`timescale 1ns/1ps
module sdx_lane_shifter #(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned LEAD_Z  = 2,
  parameter int unsigned TRAIL_Z = 2,
  localparam int unsigned SLOT_W = LEAD_Z + DATA_W + TRAIL_Z,
  localparam int unsigned WORD_W = 2 * SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic              shift,
  input  logic [DATA_W-1:0] own,
  input  logic [DATA_W-1:0] other,
  output logic              dout
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (load)
      word_q <= {{LEAD_Z{1'b0}}, own, {(TRAIL_Z + LEAD_Z){1'b0}}, other,
                 {TRAIL_Z{1'b0}}};
    else if (clear) word_q <= '0;
    else if (shift) word_q <= {word_q[WORD_W-2:0], 1'b0};
  end

  assign dout = word_q[WORD_W-1];
endmodule

// File: rtl/serial_adc_shifter.sv
`timescale 1ns/1ps
module serial_adc_shifter
  import sdx_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned LEAD_Z  = DEF_LEAD_Z,
  parameter int unsigned TRAIL_Z = DEF_TRAIL_Z
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] res_a,
  input  logic [DATA_W-1:0] res_b,
  output logic              dout_a,
  output logic              oe_a,
  output logic              dout_b,
  output logic              oe_b,
  output logic              track_hold
);
  localparam int unsigned SLOT_W  = LEAD_Z + DATA_W + TRAIL_Z;
  localparam int unsigned TOTAL   = N_CHAN * SLOT_W;
  localparam int unsigned HOLD_AT = LEAD_Z - 1 + DATA_W;

  edge_t cs_ev, sk_ev;
  logic  ld, clr, sh, act;
  logic  [DATA_W-1:0] res [N_CHAN];
  logic  [N_CHAN-1:0] lane_bit;

  assign res[0] = res_a;
  assign res[1] = res_b;

  sdx_edge_detect #(.IDLE(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .din(cs_n), .ev(cs_ev));
  sdx_edge_detect #(.IDLE(1'b1)) u_sk_edge (
    .clk(clk), .rst_n(rst_n), .din(sclk), .ev(sk_ev));

  sdx_frame_ctrl #(.TOTAL(TOTAL), .HOLD_AT(HOLD_AT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_ev(cs_ev), .sk_ev(sk_ev),
    .load(ld), .clear(clr), .shift(sh), .active(act), .hold(track_hold));

  generate
    for (genvar i = 0; i < N_CHAN; i++) begin : g_lane
      sdx_lane_shifter #(.DATA_W(DATA_W), .LEAD_Z(LEAD_Z), .TRAIL_Z(TRAIL_Z)) u_lane (
        .clk(clk), .rst_n(rst_n), .load(ld), .clear(clr), .shift(sh),
        .own(res[i]), .other(res[N_CHAN-1-i]), .dout(lane_bit[i]));
    end
  endgenerate

  assign dout_a = lane_bit[0];
  assign dout_b = lane_bit[1];
  assign oe_a   = act;
  assign oe_b   = act;
endmodule

// File: rtl/sdx_checker.sv
`timescale 1ns/1ps
module sdx_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic dout_a,
  input logic oe_a,
  input logic dout_b,
  input logic oe_b,
  input logic track_hold
);
  logic cq, sq;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin cq <= 1'b1; sq <= 1'b1; end
    else        begin cq <= cs_n; sq <= sclk; end
  end

  assert_open_on_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cq && !cs_n) |=> (oe_a && oe_b && track_hold && !dout_a && !dout_b));

  assert_hold_rises_on_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(track_hold) |-> $past(cq && !cs_n));

  assert_hold_falls_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(track_hold) |-> $past((!sq && sclk) || (!cq && cs_n)));

  assert_release_on_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cq && cs_n) |=> (!oe_a && !oe_b && !track_hold));

  assert_quiet_when_off_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_a |-> !dout_a);

  assert_quiet_when_off_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_b |-> !dout_b);

  assert_lanes_move_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cq == cs_n) && !(sq && !sclk)) |=> ($stable(dout_a) && $stable(dout_b)));
endmodule

bind serial_adc_shifter sdx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
  .dout_a(dout_a), .oe_a(oe_a), .dout_b(dout_b), .oe_b(oe_b),
  .track_hold(track_hold));

// File: tb/sim_serial_adc_shifter.sv
`timescale 1ns/1ps
module sim_serial_adc_shifter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b1;
  logic [11:0] res_a = '0, res_b = '0;
  logic dout_a, oe_a, dout_b, oe_b, track_hold;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_adc_shifter u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .res_a(res_a), .res_b(res_b), .dout_a(dout_a), .oe_a(oe_a),
    .dout_b(dout_b), .oe_b(oe_b), .track_hold(track_hold));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected bit after k counted falls: slot = 2 zeros, 12 bits, 2 zeros
  function automatic int exp_bit(input logic [11:0] own, input logic [11:0] oth, input int k);
    logic [31:0] w;
    w = {2'b00, own, 4'b0000, oth, 2'b00};
    if (k >= 32) return 0;
    return int'(w[31-k]);
  endfunction

  function automatic string tag_of(input int k);
    if (k <= 1)  return "R2";
    if (k <= 13) return "R3";
    if (k <= 15) return "R5";
    if (k <= 31) return "R6";
    return "R8";
  endfunction

  task automatic fall_edge(); sclk = 1'b0; @(negedge clk); endtask
  task automatic rise_edge(); sclk = 1'b1; @(negedge clk); endtask

  task automatic select(input logic [11:0] a, input logic [11:0] b);
    res_a = a; res_b = b; cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic deselect(); cs_n = 1'b1; sclk = 1'b1; @(negedge clk); @(negedge clk); endtask

  task automatic t_reset();
    check("R8 reset oe_a", int'(oe_a), 0);
    check("R8 reset oe_b", int'(oe_b), 0);
    check("R1 reset hold", int'(track_hold), 0);
    check("R8 reset dout_a", int'(dout_a), 0);
  endtask

  task automatic t_full_frame(input logic [11:0] a, input logic [11:0] b);
    select(a, b);
    check("R1 oe_a", int'(oe_a), 1);
    check("R1 oe_b", int'(oe_b), 1);
    check("R1 hold", int'(track_hold), 1);
    check("R1 dout_a lead", int'(dout_a), 0);
    check("R1 dout_b lead", int'(dout_b), 0);
    for (int k = 1; k <= 32; k++) begin
      fall_edge();
      if (k == 5) begin res_a = ~a; res_b = ~b; end // R11 late input change
      check({tag_of(k), " dout_a"}, int'(dout_a), exp_bit(a, b, k));
      check({tag_of(k), " dout_b"}, int'(dout_b), exp_bit(b, a, k));
      check(k == 32 ? "R8 oe_a" : "R11 oe_a", int'(oe_a), k < 32 ? 1 : 0);
      if (k == 12 || k == 13) check("R4 hold before rise", int'(track_hold), 1);
      rise_edge();
      if (k == 12 || k == 13) check("R4 hold after rise", int'(track_hold), k < 13 ? 1 : 0);
    end
    for (int j = 0; j < 3; j++) begin
      fall_edge(); rise_edge();
    end
    check("R8 stays off oe_a", int'(oe_a), 0);
    check("R8 stays off oe_b", int'(oe_b), 0);
    check("R8 stays off dout_a", int'(dout_a), 0);
    check("R8 stays off dout_b", int'(dout_b), 0);
    deselect();
  endtask

  task automatic t_early_deselect();
    select(12'hFFF, 12'hFFF);
    for (int k = 1; k <= 5; k++) begin fall_edge(); rise_edge(); end
    check("R3 mid bit", int'(dout_a), 1);
    cs_n = 1'b1;
    @(negedge clk);
    check("R7 oe_a", int'(oe_a), 0);
    check("R7 oe_b", int'(oe_b), 0);
    check("R7 hold", int'(track_hold), 0);
    check("R7 dout_a", int'(dout_a), 0);
    deselect();
  endtask

  task automatic t_coincident();
    res_a = 12'h800; res_b = 12'h7FF;
    cs_n = 1'b0; sclk = 1'b0;
    @(negedge clk);
    check("R9 oe_a", int'(oe_a), 1);
    check("R9 lead", int'(dout_a), 0);
    rise_edge(); fall_edge();
    check("R9 second lead a", int'(dout_a), 0);
    check("R9 second lead b", int'(dout_b), 0);
    rise_edge(); fall_edge();
    check("R9 bit11 a", int'(dout_a), 1);
    check("R9 bit11 b", int'(dout_b), 0);
    deselect();
  endtask

  task automatic t_early_rise();
    sclk = 1'b0;
    @(negedge clk); @(negedge clk);
    select(12'h9AB, 12'h1AB);
    rise_edge();
    check("R10 dout_a", int'(dout_a), 0);
    check("R10 hold", int'(track_hold), 1);
    check("R10 oe_a", int'(oe_a), 1);
    fall_edge();
    check("R10 second lead", int'(dout_a), 0);
    rise_edge(); fall_edge();
    check("R10 bit11 a", int'(dout_a), 1);
    check("R10 bit11 b", int'(dout_b), 0);
    rise_edge(); fall_edge();
    check("R10 bit10 a", int'(dout_a), 0);
    check("R10 bit10 b", int'(dout_b), 0);
    deselect();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_frame(12'hA5C, 12'h3E1);
    t_full_frame(12'h001, 12'hFFE);
    t_early_deselect();
    t_coincident();
    t_early_rise();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule